// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Generator

The block drives up to four independent pulse-width outputs from a shared source clock. Each channel owns one 32-bit configuration word on a small memory-mapped write/read bus. The word holds a clock divider, an 8-bit duty count, a flag that forces the output fully on, and an enable. The divider slows the source clock into ticks. A fixed 256-tick counter then frames one period, so the period lasts 256 × (divider + 1) source clocks. The output is high while the tick count within the period is below the duty count.

Changes take effect at once. Any write to a channel restarts its divider and its tick counter from zero, so new settings begin a fresh period on the very next cycle. Clearing the enable pulls the output low on the next clock and abandons the period in progress. Software reads back exactly what it wrote, with the unused bits shown as zero.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every configuration word reads as zero.
- R2: A channel word places the divider in bits [12:0], the duty count in bits [23:16], the force-full flag in bit 24 and the enable in bit 31. A read returns the last value written to that channel, with all other bits zero.
- R3: Address bits [5:4] select the channel and bits [3:0] are ignored. A write changes only the selected channel's word and output.
- R4: An enabled channel advances its tick count once every divider+1 source clocks, so one period lasts 256 × (divider + 1) clocks and then repeats.
- R5: With the force-full flag clear, the output is high for the first duty × (divider + 1) clocks of each period and low for the rest. A duty of 0 keeps it low for the whole period, and a duty of 255 makes it low only for the final tick.
- R6: With the force-full flag set and the channel enabled, the output stays high for every cycle and the duty count has no effect.
- R7: A write that clears the enable drives the output low from the cycle after the write edge, even in the middle of a period, and the output stays low.
- R8: Any write to a channel restarts its period at once: the cycle after the write edge is tick 0 of a new period, under the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock, which is also the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W (6) | Byte address; bits [5:4] pick the channel |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read of the addressed channel word |
| pwmOut | output | NUM_CH (4) | Active-high pulse outputs, one per channel |

## Verification
Several properties are checked on every cycle. The divider count never exceeds the programmed divider. The tick count steps by exactly one on each divider wrap. A forced-full channel is high whenever it is enabled. The first cycle after any write already shows the new settings. A disabling write brings the output low on the next cycle. Read data never shows bits outside the defined fields. Two things are visible only through the bench's scenarios, which compare every output sample against a model: that the high run of each period has the exact length duty × (divider + 1), and that periods keep repeating over many frames with random settings. Isolation between channels is also checked this way, because all four channels run together while one of them is rewritten.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Field layout of a channel word (bit positions are decoded by software)
  localparam int DIV_W    = 13;
  localparam int DUTY_W   = 8;
  localparam int DUTY_LSB = 16;
  localparam int FULL_BIT = 24;
  localparam int EN_BIT   = 31;
  localparam int WORD_W   = 32;
  localparam int SEL_LSB  = 4;   // channel stride of 16 bytes
  localparam logic [WORD_W-1:0] FIELD_MASK = 32'h81FF_1FFF;

  typedef struct packed {
    logic              en;
    logic              full;
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
  } chanCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
  } ctlStrobe_t;

  function automatic chanCfg_t unpackCfg(input logic [WORD_W-1:0] w);
    chanCfg_t c;
    c.en   = w[EN_BIT];
    c.full = w[FULL_BIT];
    c.duty = w[DUTY_LSB +: DUTY_W];
    c.div  = w[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] packCfg(input chanCfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]               = c.en;
    w[FULL_BIT]             = c.full;
    w[DUTY_LSB +: DUTY_W]   = c.duty;
    w[DIV_W-1:0]            = c.div;
    return w;
  endfunction
endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output chanCfg_t          cfg    [NUM_CH],
  output ctlStrobe_t        strobe [NUM_CH]
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [SEL_W-1:0] chSel;
  logic [NUM_CH-1:0] hit;
  chanCfg_t cfgQ [NUM_CH];

  assign chSel = busAddr[SEL_LSB +: SEL_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign hit[g]            = busWe && (chSel == SEL_W'(g));
    assign strobe[g].restart = hit[g];
    assign cfg[g]            = cfgQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) cfgQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (hit[i]) cfgQ[i] <= unpackCfg(busWdata);
    end
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (chSel == SEL_W'(i)) busRdata = packCfg(cfgQ[i]);
  end

  // R2: read data never carries bits outside the defined fields
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~FIELD_MASK) == '0);
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  chanCfg_t   cfg,
  input  ctlStrobe_t strobe,
  output logic       pwmOut
);
  logic [DIV_W-1:0]  preCnt;
  logic [DUTY_W-1:0] stepCnt;
  logic              preWrap;

  assign preWrap = (preCnt == cfg.div);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (strobe.restart || !cfg.en) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (preWrap) begin
      preCnt  <= '0;
      stepCnt <= stepCnt + 1'b1;   // wraps after 256 ticks
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  assign pwmOut = cfg.en && (cfg.full || (stepCnt < cfg.duty));

  // R4: divider count stays inside the programmed range
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfg.en |-> (preCnt <= cfg.div));

  // R4: each divider wrap moves the tick count on by exactly one
  p_step_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && !strobe.restart && preWrap) |=>
      (stepCnt == DUTY_W'($past(stepCnt) + 1'b1)));

  // R6: forced-full channel is high whenever enabled
  p_full_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.full) |-> pwmOut);

  // R8: first cycle after a write is tick 0 of the new settings
  p_fresh_period_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (pwmOut == (cfg.en && (cfg.full || (cfg.duty != '0)))));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  chanCfg_t   cfg    [NUM_CH];
  ctlStrobe_t strobe [NUM_CH];

  pwm_bank_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cfg(cfg), .strobe(strobe)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk(clk), .rstN(rstN), .cfg(cfg[g]), .strobe(strobe[g]),
      .pwmOut(pwmOut[g])
    );

    // R7: a write clearing the enable silences the output on the next cycle
    p_disable_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && (busAddr[SEL_LSB +: SEL_W] == SEL_W'(g)) && !busWdata[EN_BIT])
        |=> !pwmOut[g]);
  end
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NUM_CH = 4;
  localparam logic [31:0] MASK = 32'h81FF_1FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NUM_CH-1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  logic [31:0] shadow [NUM_CH];
  longint startCyc [NUM_CH];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(6)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // model output of a channel word at cycle idx of its period sequence
  function automatic bit expOut(input logic [31:0] w, input longint idx);
    longint tick;
    if (!w[31]) return 1'b0;
    if (w[24]) return 1'b1;
    tick = (idx / (longint'(w[12:0]) + 1)) % 256;
    return tick < longint'(w[23:16]);
  endfunction

  task automatic writeReg(input int ch, input logic [31:0] w, input logic [3:0] low);
    longint wc;
    @(negedge clk);
    busWe = 1'b1; busAddr = {2'(ch), low}; busWdata = w;
    wc = cyc;
    @(negedge clk);
    busWe = 1'b0;
    shadow[ch] = w & MASK;
    startCyc[ch] = wc + 1;
  endtask

  task automatic readCheck(input int ch, input string tag);
    @(negedge clk);
    busAddr = {2'(ch), 4'h0};
    #1;
    check(busRdata === shadow[ch], tag, $sformatf("readback ch%0d", ch),
          busRdata, shadow[ch]);
  endtask

  task automatic watch(input int n, input string tag);
    int bad [NUM_CH];
    for (int c = 0; c < NUM_CH; c++) bad[c] = 0;
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < NUM_CH; c++)
        if (pwmOut[c] !== expOut(shadow[c], cyc - startCyc[c])) bad[c]++;
      @(negedge clk);
    end
    for (int c = 0; c < NUM_CH; c++)
      check(bad[c] == 0, tag, $sformatf("wave ch%0d mismatched cycles", c), bad[c], 0);
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2024));
    for (int c = 0; c < NUM_CH; c++) begin shadow[c] = '0; startCyc[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(pwmOut === '0, "R1", "outputs after reset", pwmOut, 0);
    for (int c = 0; c < NUM_CH; c++) readCheck(c, "R1");

    // R2: field masking on read-back
    writeReg(1, 32'hFFFF_FFFF, 4'h0);
    readCheck(1, "R2");
    writeReg(1, 32'h7E00_E000, 4'h0);   // only undefined bits set
    readCheck(1, "R2");

    // R5: duty 0 stays low; R10-style fastest period with half duty
    writeReg(0, 32'h8000_0002, 4'h0);
    writeReg(1, 32'h8080_0000, 4'h0);   // divider 0, duty 128
    watch(600, "R5");
    // R6: full flag overrides the duty field
    writeReg(2, 32'h8140_0001, 4'h0);
    writeReg(3, 32'h8100_0000, 4'h0);
    watch(600, "R6");

    // R5: duty 255 drops only for the last tick
    writeReg(0, 32'h80FF_0000, 4'h0);
    watch(520, "R5");

    // R4: large divider, tick boundaries at 1001 clocks
    writeReg(3, 32'h8002_03E8, 4'h0);
    watch(3100, "R4");

    // R3: low address bits ignored, other channels untouched
    writeReg(1, 32'h8030_0001, 4'h0);
    watch(200, "R3");
    writeReg(2, 32'h8011_0002, 4'hB);
    readCheck(2, "R3");
    readCheck(1, "R3");
    watch(900, "R3");

    // R8: rewrite mid-period restarts at tick 0
    writeReg(1, 32'h8060_0002, 4'h0);
    watch(333, "R8");
    writeReg(1, 32'h8020_0000, 4'h0);
    check(pwmOut[1] === 1'b1, "R8", "first cycle after rewrite", pwmOut[1], 1);
    watch(600, "R8");

    // R7: disable mid-period goes low at once and stays low
    writeReg(2, 32'h81FF_0003, 4'h0);
    watch(150, "R7");
    writeReg(2, 32'h01FF_0003, 4'h0);
    check(pwmOut[2] === 1'b0, "R7", "output after disable", pwmOut[2], 0);
    watch(400, "R7");
    readCheck(2, "R7");

    // R4/R5 random settings on all channels
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        w = $urandom;
        w[12:0] = 13'($urandom % 4);
        w[31] = ($urandom % 5) != 0;
        w[24] = ($urandom % 6) == 0;
        writeReg(c, w, 4'($urandom));
        readCheck(c, "R2");
      end
      watch(2100, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule